// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block keeps a 64-bit count of clock cycles for timing code sections. Software programs it through a small synchronous register bus: a control word that starts and stops counting, selects a divide-by-64 prescale, chooses which counter bit reports a wrap, and fires self-clearing reset strobes; two words that read and load the counter halves; a sticky overflow status word; and an access-enable word that decides whether unprivileged software may use the block at all.

Counting begins only after software sets the run bit. A separate counting-prohibited input can freeze the counter when the matching control bit is set. The counter can be loaded or cleared at any time, so it also serves as a resettable interval timer. Clearing it never hides a wrap that has already been recorded. A strobe bit sends a one-cycle clear pulse to event counters outside the block.

Read data is registered and appears on the cycle after the read strobe. Bus addresses: 0 control, 1 counter bits 31:0, 2 counter bits 63:32, 3 overflow status, 4 access enable. Every other address reads as zero.

Top module: `cyccnt_unit`

## Requirements
- R1: Control reads return the implementer code in bits 31:24, the identification code in 23:16 and the event-counter count in 15:11. Bits 10:7, 4, 2 and 1 read 0. Bits 6 (wrap select), 5 (hold on prohibit), 3 (divide) and 0 (run) read back as written.
- R2: After reset the counter is 0 and stays there while run (bit 0) is 0. With run set, no divide and no hold, it advances by 1 on every clock.
- R3: Writing control with bit 2 set clears the counter on that write's clock edge, so it counts on from 0. Bit 2 reads 0.
- R4: Writing control with bit 1 set drives the event-clear output high for exactly the one cycle after the write edge. Bit 1 reads 0.
- R5: Bit 31 of the overflow status word (address 3) is set when the counter carries out of bit 31 while wrap select is 0. It is set when the counter carries out of bit 63 while wrap select is 1.
- R6: The overflow bit is sticky. Writing 1 to status bit 31 is the only way to clear it. A counter clear through control bit 2 leaves it set.
- R7: With divide set, the counter advances once per 64 clocks. Any counter clear, any load, and any change of the divide bit restart the prescale. A load done with divide set is followed by the first increment 64 edges later.
- R8: With hold (bit 5) set and the prohibit input high, the counter keeps its value. With hold clear, the prohibit input has no effect.
- R9: Addresses 1 and 2 load the low and high counter halves, and a later read returns the loaded value. Each read returns the value from the edge at which the read strobe was sampled. The high half takes the carry from the low half. Unmapped addresses read 0.
- R10: With access enable (address 4, bit 0) clear, an unprivileged read returns 0 and pulses the access-error output for one cycle. With access enable set, unprivileged reads return normal data with no error.
- R11: The access-enable word accepts only privileged writes. Other unprivileged writes are dropped while access enable is clear.
- R12: Reset sets read data, access error, event clear, the overflow status and all control and enable state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High for a privileged access |
| count_prohibit | input | 1 | High while counting is prohibited |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| bus_acc_err | output | 1 | One-cycle pulse when an unprivileged read is refused |
| evt_clr_pulse | output | 1 | One-cycle clear strobe to external event counters |

## Verification
The assertions assume the bus issues at most one read or one write per cycle and holds its strobes, address and data stable through the sampling edge. They also assume the counter width is exactly twice the bus width. The stimulus drives every strobe for a single cycle away from the clock edge and never asserts read and write together. It changes the privilege and prohibit inputs only between accesses, so each access sees one fixed privilege level and hold condition.

// File: rtl/cyccnt_pkg.sv
package cyccnt_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_OVF    = 3'd3,
    A_ACC    = 3'd4
  } addr_e;

  // control word bit positions
  localparam int B_RUN   = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CLR   = 2;
  localparam int B_DIV   = 3;
  localparam int B_HOLD  = 5;
  localparam int B_LONG  = 6;

  // overflow status bit position
  localparam int B_OVF   = 31;

endpackage

// File: rtl/cyccnt_prescale.sv
module cyccnt_prescale #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic div_i,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (PRE_W == 0) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_d;
      logic             pre_en;

      always_comb begin
        pre_en = clr_i | (run_i & div_i);
        if (clr_i) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign tick_o = run_i & (~div_i | (&pre_q));

      // R7
      div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i && !clr_i) |=> (pre_q == '0));

      // R7
      div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));
    end
  endgenerate

endmodule

// File: rtl/cyccnt_core.sv
module cyccnt_core #(
  parameter int LO_W  = 32,
  localparam int CNT_W = 2 * LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [LO_W-1:0]  wdata_i,
  input  logic             inc_i,
  input  logic             long_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             ovf_q;
  logic             ovf_d;
  logic             wrap;
  logic             ovf_set;
  logic             load;

  always_comb begin
    load   = wr_lo_i | wr_hi_i;
    wrap   = long_i ? (&cnt_q) : (&cnt_q[LO_W-1:0]);
    cnt_en = clr_i | load | inc_i;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (load) begin
      if (wr_lo_i) cnt_d[LO_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:LO_W] = wdata_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    ovf_set = inc_i & wrap & ~clr_i & ~load;
    ovf_d   = ovf_set | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));

  // R5
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(long_i) ? (&$past(cnt_q)) : (&$past(cnt_q[LO_W-1:0]))));

endmodule

// File: rtl/cyccnt_regs.sv
module cyccnt_regs
  import cyccnt_pkg::*;
#(
  parameter logic [7:0] IMPL_CODE  = 8'h5A,
  parameter logic [7:0] IDENT_CODE = 8'h3C,
  parameter logic [4:0] NUM_EVT    = 5'd6,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              priv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_i,
  output logic              run_o,
  output logic              div_o,
  output logic              hold_o,
  output logic              long_o,
  output logic              cnt_clr_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              ovf_clr_o,
  output logic              pre_clr_o,
  output logic              evt_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              acc_err_o
);

  addr_e            addr;
  logic             gate_ok;
  logic             we_ok;
  logic             ctrl_we;
  logic             acc_we;

  logic             run_q,  run_d;
  logic             div_q,  div_d;
  logic             hold_q, hold_d;
  logic             long_q, long_d;
  logic             acc_q,  acc_d;
  logic             evt_q,  evt_d;
  logic             err_q,  err_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic [BUS_W-1:0] rd_val;
  logic [BUS_W-1:0] ctrl_word;

  always_comb begin
    addr    = addr_e'(addr_i);
    gate_ok = priv_i | acc_q;
    we_ok   = we_i & gate_ok;
    ctrl_we = we_ok & (addr == A_CTRL);
    acc_we  = we_i & priv_i & (addr == A_ACC);

    cnt_clr_o = ctrl_we & wdata_i[B_CLR];
    wr_lo_o   = we_ok & (addr == A_CNT_LO);
    wr_hi_o   = we_ok & (addr == A_CNT_HI);
    ovf_clr_o = we_ok & (addr == A_OVF) & wdata_i[B_OVF];
    pre_clr_o = cnt_clr_o | wr_lo_o | wr_hi_o |
                (ctrl_we & (wdata_i[B_DIV] != div_q));

    run_d  = ctrl_we ? wdata_i[B_RUN]  : run_q;
    div_d  = ctrl_we ? wdata_i[B_DIV]  : div_q;
    hold_d = ctrl_we ? wdata_i[B_HOLD] : hold_q;
    long_d = ctrl_we ? wdata_i[B_LONG] : long_q;
    acc_d  = acc_we  ? wdata_i[0]      : acc_q;
    evt_d  = ctrl_we & wdata_i[B_EVCLR];
  end

  always_comb begin
    ctrl_word = {IMPL_CODE, IDENT_CODE, NUM_EVT, 4'b0000,
                 long_q, hold_q, 1'b0, div_q, 2'b00, run_q};
    case (addr)
      A_CTRL:   rd_val = ctrl_word;
      A_CNT_LO: rd_val = cnt_i[BUS_W-1:0];
      A_CNT_HI: rd_val = cnt_i[CNT_W-1:BUS_W];
      A_OVF:    rd_val = {ovf_i, {(BUS_W-1){1'b0}}};
      A_ACC:    rd_val = {{(BUS_W-1){1'b0}}, acc_q};
      default:  rd_val = '0;
    endcase
    rdata_d = (re_i & gate_ok) ? rd_val : '0;
    err_d   = re_i & ~gate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      hold_q <= 1'b0;
      long_q <= 1'b0;
    end else if (ctrl_we) begin
      run_q  <= run_d;
      div_q  <= div_d;
      hold_q <= hold_d;
      long_q <= long_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
    end else if (acc_we) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      evt_q   <= evt_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign run_o     = run_q;
  assign div_o     = div_q;
  assign hold_o    = hold_q;
  assign long_o    = long_q;
  assign evt_o     = evt_q;
  assign rdata_o   = rdata_q;
  assign acc_err_o = err_q;

  // R4
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(we_i && (addr_i == A_CTRL) && wdata_i[B_EVCLR]));

  // R10
  refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> (rdata_o == '0));

  // R11
  acc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !priv_i && (addr_i == A_ACC)) |=> $stable(acc_q));

  // R1
  ctrl_strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re_i && gate_ok && (addr_i == A_CTRL)) |=> (rdata_o[2:1] == 2'b00 && rdata_o[4] == 1'b0));

endmodule

// File: rtl/cyccnt_unit.sv
module cyccnt_unit
  import cyccnt_pkg::*;
#(
  parameter logic [7:0] IMPL_CODE  = 8'h5A,
  parameter logic [7:0] IDENT_CODE = 8'h3C,
  parameter logic [4:0] NUM_EVT    = 5'd6,
  parameter int         PRE_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_priv,
  input  logic              count_prohibit,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_acc_err,
  output logic              evt_clr_pulse
);

  localparam int CNT_W = 2 * BUS_W;

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic             run, div, hold, long_sel;
  logic             cnt_clr, wr_lo, wr_hi, ovf_clr, pre_clr;
  logic             active, tick, inc;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cyccnt_regs #(
    .IMPL_CODE  (IMPL_CODE),
    .IDENT_CODE (IDENT_CODE),
    .NUM_EVT    (NUM_EVT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .addr_i    (bus_addr),
    .we_i      (bus_we),
    .re_i      (bus_re),
    .wdata_i   (bus_wdata),
    .priv_i    (bus_priv),
    .cnt_i     (cnt),
    .ovf_i     (ovf),
    .run_o     (run),
    .div_o     (div),
    .hold_o    (hold),
    .long_o    (long_sel),
    .cnt_clr_o (cnt_clr),
    .wr_lo_o   (wr_lo),
    .wr_hi_o   (wr_hi),
    .ovf_clr_o (ovf_clr),
    .pre_clr_o (pre_clr),
    .evt_o     (evt_clr_pulse),
    .rdata_o   (bus_rdata),
    .acc_err_o (bus_acc_err)
  );

  assign active = run & ~(hold & count_prohibit);

  cyccnt_prescale #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (active),
    .div_i  (div),
    .clr_i  (pre_clr),
    .tick_o (tick)
  );

  assign inc = tick;

  cyccnt_core #(
    .LO_W (BUS_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr_i     (cnt_clr),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wdata_i   (bus_wdata),
    .inc_i     (inc),
    .long_i    (long_sel),
    .ovf_clr_i (ovf_clr),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  // R8
  prohibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (hold && count_prohibit && !cnt_clr && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R2
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!run && !cnt_clr && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R6
  clr_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cnt_clr && ovf && !ovf_clr) |=> ovf);

endmodule

// File: tb/cyccnt_unit_bench.sv
module cyccnt_unit_bench;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_LO   = 3'd1;
  localparam logic [2:0] A_HI   = 3'd2;
  localparam logic [2:0] A_OVF  = 3'd3;
  localparam logic [2:0] A_ACC  = 3'd4;
  localparam logic [31:0] ID_BITS = 32'h5A3C_3000;

  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, A_CTRL, 32'h0,         ID_BITS,       4'd1},  // R1 ident fields
    '{OP_RD, A_OVF,  32'h0,         32'h0,         4'd12}, // R12
    '{OP_RD, A_ACC,  32'h0,         32'h0,         4'd12}, // R12
    '{OP_RD, A_LO,   32'h0,         32'h0,         4'd2},  // R2 stopped
    '{OP_RD, A_HI,   32'h0,         32'h0,         4'd12}, // R12
    '{OP_RD, A_LO,   32'h0,         32'h0,         4'd2},  // R2 stopped
    '{OP_WR, A_CTRL, 32'h1,         32'h0,         4'd2},
    '{OP_WR, A_LO,   32'h100,       32'h0,         4'd9},
    '{OP_RD, A_LO,   32'h0,         32'h100,       4'd9},  // R9 load
    '{OP_RD, A_LO,   32'h0,         32'h101,       4'd2},  // R2 per clock
    '{OP_WR, A_CTRL, 32'hFFFF_07F9, 32'h0,         4'd1},
    '{OP_RD, A_CTRL, 32'h0,         ID_BITS | 32'h69, 4'd1}, // R1 masking
    '{OP_WR, A_CTRL, 32'h5,         32'h0,         4'd3},
    '{OP_RD, A_CTRL, 32'h0,         ID_BITS | 32'h1,  4'd3}, // R3 reads 0
    '{OP_RD, A_LO,   32'h0,         32'h1,         4'd3},  // R3 cleared
    '{OP_WR, A_HI,   32'hAB,        32'h0,         4'd9},
    '{OP_RD, A_HI,   32'h0,         32'hAB,        4'd9},  // R9 high load
    '{OP_WR, A_ACC,  32'h1,         32'h0,         4'd11},
    '{OP_RD, A_ACC,  32'h0,         32'h1,         4'd11}, // R11 priv write
    '{OP_RD, 3'd7,   32'h0,         32'h0,         4'd9}   // R9 unmapped
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_wdata;
  logic        bus_priv;
  logic        count_prohibit;
  logic [31:0] bus_rdata;
  logic        bus_acc_err;
  logic        evt_clr_pulse;

  int total;
  int bad;
  logic last_err;
  bit finished;

  cyccnt_unit u_cyccnt_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_wdata      (bus_wdata),
    .bus_priv       (bus_priv),
    .count_prohibit (count_prohibit),
    .bus_rdata      (bus_rdata),
    .bus_acc_err    (bus_acc_err),
    .evt_clr_pulse  (evt_clr_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    last_err = bus_acc_err;
    chk(tag, bus_rdata, exp);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired, run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0; last_err = 0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0;
    bus_priv = 1'b1; count_prohibit = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R12 reset state at the outputs
    chk("R12 rdata", bus_rdata, 32'h0);
    chk("R12 acc_err", {31'b0, bus_acc_err}, 32'h0);
    chk("R12 evt", {31'b0, evt_clr_pulse}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == OP_WR) begin
        wr(VECS[i].addr, VECS[i].data);
      end else if (VECS[i].op == OP_RD) begin
        rd(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      end else begin
        idle(1);
      end
    end

    // R4 event clear strobe: one cycle, after the write edge
    wr(A_CTRL, 32'h3);
    chk("R4 pulse high", {31'b0, evt_clr_pulse}, 32'h1);
    idle(1);
    chk("R4 pulse gone", {31'b0, evt_clr_pulse}, 32'h0);

    // R5 wrap from bit 31 with select 0
    wr(A_CTRL, 32'h1);
    wr(A_HI, 32'h0);
    wr(A_LO, 32'hFFFF_FFFE);
    idle(4);
    rd(A_OVF, 32'h8000_0000, "R5 low wrap sets");
    rd(A_HI, 32'h1, "R9 carry into high");
    // R6 sticky through counter clear and through a write without bit 31
    wr(A_CTRL, 32'h5);
    rd(A_OVF, 32'h8000_0000, "R6 kept over clear");
    wr(A_OVF, 32'h0000_0001);
    rd(A_OVF, 32'h8000_0000, "R6 kept over bit0 write");
    wr(A_OVF, 32'h8000_0000);
    rd(A_OVF, 32'h0, "R6 cleared by w1c");

    // R5 select 1: only the 64-bit wrap counts
    wr(A_CTRL, 32'h41);
    wr(A_HI, 32'h0);
    wr(A_LO, 32'hFFFF_FFFE);
    idle(4);
    rd(A_OVF, 32'h0, "R5 low wrap ignored");
    wr(A_HI, 32'hFFFF_FFFF);
    wr(A_LO, 32'hFFFF_FFFE);
    idle(4);
    rd(A_OVF, 32'h8000_0000, "R5 full wrap sets");
    rd(A_HI, 32'h0, "R5 high wrapped");
    wr(A_OVF, 32'h8000_0000);

    // R7 divide by 64: first increment 64 edges after the load
    wr(A_CTRL, 32'h9);
    wr(A_LO, 32'h0);
    idle(63);
    rd(A_LO, 32'h0, "R7 before 64th edge");
    rd(A_LO, 32'h1, "R7 after 64th edge");

    // R8 hold while prohibited
    count_prohibit = 1'b1;
    wr(A_CTRL, 32'h21);
    wr(A_LO, 32'h50);
    idle(10);
    rd(A_LO, 32'h50, "R8 held");
    wr(A_CTRL, 32'h01);
    wr(A_LO, 32'h50);
    rd(A_LO, 32'h50, "R8 no hold bit");
    rd(A_LO, 32'h51, "R8 no hold bit counts");
    count_prohibit = 1'b0;

    // R2 run bit cleared stops counting
    wr(A_CTRL, 32'h0);
    wr(A_LO, 32'h7);
    idle(5);
    rd(A_LO, 32'h7, "R2 stopped");

    // R11 and R10 access gate
    wr(A_ACC, 32'h0);
    bus_priv = 1'b0;
    wr(A_LO, 32'h99);
    bus_priv = 1'b1;
    rd(A_LO, 32'h7, "R11 unpriv write dropped");
    bus_priv = 1'b0;
    wr(A_ACC, 32'h1);
    bus_priv = 1'b1;
    rd(A_ACC, 32'h0, "R11 acc word locked");
    bus_priv = 1'b0;
    rd(A_CTRL, 32'h0, "R10 refused read data");
    chk("R10 err pulse", {31'b0, last_err}, 32'h1);
    idle(1);
    chk("R10 err one cycle", {31'b0, bus_acc_err}, 32'h0);
    bus_priv = 1'b1;
    wr(A_ACC, 32'h1);
    bus_priv = 1'b0;
    rd(A_CTRL, ID_BITS, "R10 allowed read");
    chk("R10 no err", {31'b0, last_err}, 32'h0);
    bus_priv = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule